// File: doc/BRIEF.md
# Forward-Euler Piecewise-Linear Chaotic Oscillator Node

This block holds the three state variables of a normalized double-scroll chaotic oscillator and advances them by one forward-Euler step each time a step is requested. The arithmetic is fixed point throughout. Every state, the coupling input and the initial values are signed two's-complement Q8.16 words: 24 bits, with 16 fraction bits. The model constants are Q16 integers. The nonlinearity has three linear segments and is computed exactly from two absolute values, with no lookup table. The step size is a power of two, so it is applied as an arithmetic right shift.

A network controller is expected to compute the diffusive coupling term for this node and present it on the coupling input. It then pulses the start input and collects the new state when the done strobe fires. Several nodes stepped together in this way form a coupled network. A synchronous load port sets the initial conditions. After reset the node holds fixed default initial conditions.

Top module: `pwl_euler_node`

## Requirements
- R1: After reset the states read x1 = 0x008000 (0.5), x2 = 0x004000 (0.25) and x3 = 0x002000 (0.125), and done is low.
- R2: When load is high at a clock edge, the three states take the load values at that edge. Load wins over start, cancels a step that was already accepted, and produces no done.
- R3: A start that is seen while the node is idle is accepted at that edge. At the following edge the new state appears and done is high for exactly that one cycle.
- R4: A start seen while an accepted step is still pending has no effect, so holding start for two cycles produces exactly one step.
- R5: With no load and no step in progress, all three states stay unchanged whatever the coupling input does.
- R6: f(x) = rb(x) + rh(|x+1| − |x−1|) is computed in exact wide arithmetic. Here rm(v) is round(v·K / 2^16) with ties rounded upward, using K_b = −46793 (−0.714) and K_h = −14057, which is half of (−1.143 + 0.714).
- R7: The first derivative is d1 = rα(x2 − x1 − f(x1)) + u, with K_α = 1022362 (15.6). The value of u is sampled at the edge where the step is accepted.
- R8: The other derivatives are d2 = x1 − x2 + x3 and d3 = −rβ(x2), with K_β = 1835008 (28).
- R9: Each new state is sat(x_i + (d_i >>> 7)), where τ = 2^-7. Every derivative is formed from the old values of all three states.
- R10: A sum above 0x7FFFFF gives 0x7FFFFF, and a sum below −0x800000 gives 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Write the initial-state values |
| ld_x1 | input | 24 | Initial value for state 1 (Q8.16) |
| ld_x2 | input | 24 | Initial value for state 2 (Q8.16) |
| ld_x3 | input | 24 | Initial value for state 3 (Q8.16) |
| start | input | 1 | Request one Euler step |
| coup_u | input | 24 | Coupling term added to the first derivative (Q8.16) |
| x1 | output | 24 | State 1 |
| x2 | output | 24 | State 2 |
| x3 | output | 24 | State 3 |
| done | output | 1 | One-cycle strobe when the new state is visible |

## Verification
A long chain of back-to-back steps, run with zero coupling from the reset state, follows the chaotic trajectory. This chain exposes any mismatch in rounding, in the order of operations, or in mixing old and new state values. Single steps loaded with first-state values inside the unit band, outside it and negative tell the middle slope apart from the outer slopes. Runs with positive and negative coupling show that u reaches the first derivative only. Extreme loads in both directions drive the first state into clipping. Load collisions with a pending or a simultaneous start, and idle periods while the coupling input changes, separate the priority, cancel and hold behaviour.

// File: rtl/pwl_osc_pkg.sv
// Shared types for the Euler oscillator node.
// Assumes: nothing beyond IEEE 1800-2017.
package pwl_osc_pkg;
    typedef enum logic {PH_IDLE = 1'b0, PH_APPLY = 1'b1} osc_phase_t;
endpackage

// File: rtl/const_mul_rnd.sv
// Signed multiply by a Q-format constant, rounded to nearest (ties up) and
// truncated to OUT_W bits.
// Assumes: the caller sizes OUT_W so the rounded product never overflows.
module const_mul_rnd #(
    parameter int IN_W  = 24,
    parameter int K_W   = 24,
    parameter int OUT_W = 32,
    parameter int FRAC  = 16
) (
    input  logic signed [IN_W-1:0]  a,
    input  logic signed [K_W-1:0]   k,
    output logic signed [OUT_W-1:0] p
);
    localparam int PW = IN_W + K_W;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] rnd;

    // full-width product, rounding offset, then scale back
    always_comb begin
        full = $signed({{K_W{a[IN_W-1]}}, a}) * $signed({{IN_W{k[K_W-1]}}, k});
        rnd  = full + HALF;
        p    = OUT_W'(rnd >>> FRAC);
    end
endmodule

// File: rtl/pwl_nonlin.sv
// Three-segment odd nonlinearity f(x) = b*x + h*(|x+1| - |x-1|), where h is half
// the slope difference. The absolute values are exact; the two products are rounded.
// Assumes: DW is wide enough to hold f for any W-bit input.
module pwl_nonlin #(
    parameter int W    = 24,
    parameter int DW   = 32,
    parameter int FRAC = 16,
    parameter int K_B  = -46793,
    parameter int K_H  = -14057
) (
    input  logic signed [W-1:0]  x,
    output logic signed [DW-1:0] f
);
    localparam int ONE_I = 1 << FRAC;
    localparam logic signed [W-1:0] KB = W'(K_B);
    localparam logic signed [W-1:0] KH = W'(K_H);

    logic signed [DW-1:0] xe, xp, xm, ap, am, g, bx, hg;

    // exact breakpoint distances and their absolute difference
    always_comb begin
        xe = $signed({{(DW-W){x[W-1]}}, x});
        xp = xe + DW'(ONE_I);
        xm = xe - DW'(ONE_I);
        ap = xp[DW-1] ? -xp : xp;
        am = xm[DW-1] ? -xm : xm;
        g  = ap - am;
    end

    const_mul_rnd #(.IN_W(W), .K_W(W), .OUT_W(DW), .FRAC(FRAC)) i_mul_b (
        .a(x), .k(KB), .p(bx));
    const_mul_rnd #(.IN_W(DW), .K_W(W), .OUT_W(DW), .FRAC(FRAC)) i_mul_h (
        .a(g), .k(KH), .p(hg));

    // sum of the two segment contributions
    always_comb f = bx + hg;
endmodule

// File: rtl/euler_sat_add.sv
// One Euler accumulate: y = sat(x + (d >>> SHIFT)), clipped to the W-bit range.
// Assumes: SHIFT < DW and DW >= W.
module euler_sat_add #(
    parameter int W     = 24,
    parameter int DW    = 32,
    parameter int SHIFT = 7
) (
    input  logic signed [W-1:0]  x,
    input  logic signed [DW-1:0] d,
    output logic signed [W-1:0]  y
);
    localparam int SW = DW + 1;
    localparam logic signed [SW-1:0] MAXV = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] MINV = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [DW-1:0] inc;
    logic signed [SW-1:0] sum;

    // scaled increment, wide sum, clip to the output range
    always_comb begin
        inc = d >>> SHIFT;
        sum = $signed({{(SW-W){x[W-1]}}, x}) + $signed({inc[DW-1], inc});
        if (sum > MAXV)      y = MAXV[W-1:0];
        else if (sum < MINV) y = MINV[W-1:0];
        else                 y = sum[W-1:0];
    end
endmodule

// File: rtl/pwl_euler_node.sv
// Chaotic oscillator node: on an accepted start it captures the three derivatives
// from the current state and coupling input. One cycle later it applies
// x += d*tau with saturation and pulses done. Load has priority and cancels a
// pending step.
// Assumes: synchronous active-low reset; tau = 2^-TAU_SHIFT.
module pwl_euler_node
    import pwl_osc_pkg::*;
#(
    parameter int W         = 24,
    parameter int FRAC      = 16,
    parameter int DW        = W + 8,
    parameter int TAU_SHIFT = 7,
    parameter int K_ALPHA   = 1022362,
    parameter int K_BETA    = 1835008,
    parameter int K_B       = -46793,
    parameter int K_H       = -14057,
    parameter int INIT1     = 32768,
    parameter int INIT2     = 16384,
    parameter int INIT3     = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic signed [W-1:0] ld_x1,
    input  logic signed [W-1:0] ld_x2,
    input  logic signed [W-1:0] ld_x3,
    input  logic                start,
    input  logic signed [W-1:0] coup_u,
    output logic signed [W-1:0] x1,
    output logic signed [W-1:0] x2,
    output logic signed [W-1:0] x3,
    output logic                done
);
    localparam int NS  = 3;
    localparam int EXT = DW - W;
    localparam logic signed [W-1:0] KA = W'(K_ALPHA);
    localparam logic signed [W-1:0] KBT = W'(K_BETA);

    osc_phase_t           phase;
    logic signed [W-1:0]  st_q  [NS];
    logic signed [W-1:0]  st_nx [NS];
    logic signed [DW-1:0] d_q   [NS];
    logic signed [DW-1:0] d_nx  [NS];
    logic signed [DW-1:0] e0, e1, e2, eu, fval, inner, a_term, b_term;

    assign x1 = st_q[0];
    assign x2 = st_q[1];
    assign x3 = st_q[2];

    // sign-extended copies of the current state and coupling input
    always_comb begin
        e0 = $signed({{EXT{st_q[0][W-1]}}, st_q[0]});
        e1 = $signed({{EXT{st_q[1][W-1]}}, st_q[1]});
        e2 = $signed({{EXT{st_q[2][W-1]}}, st_q[2]});
        eu = $signed({{EXT{coup_u[W-1]}}, coup_u});
    end

    pwl_nonlin #(.W(W), .DW(DW), .FRAC(FRAC), .K_B(K_B), .K_H(K_H)) i_nonlin (
        .x(st_q[0]), .f(fval));

    // argument of the alpha product
    always_comb inner = e1 - e0 - fval;

    const_mul_rnd #(.IN_W(DW), .K_W(W), .OUT_W(DW), .FRAC(FRAC)) i_mul_alpha (
        .a(inner), .k(KA), .p(a_term));
    const_mul_rnd #(.IN_W(W), .K_W(W), .OUT_W(DW), .FRAC(FRAC)) i_mul_beta (
        .a(st_q[1]), .k(KBT), .p(b_term));

    // the three derivatives, all taken from the old state
    always_comb begin
        d_nx[0] = a_term + eu;
        d_nx[1] = e0 - e1 + e2;
        d_nx[2] = -b_term;
    end

    generate
        for (genvar i = 0; i < NS; i++) begin : g_acc
            euler_sat_add #(.W(W), .DW(DW), .SHIFT(TAU_SHIFT)) i_acc (
                .x(st_q[i]), .d(d_q[i]), .y(st_nx[i]));
        end
    endgenerate

    // control: load first, then apply a pending step, then accept a new start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q[0] <= W'(INIT1);
            st_q[1] <= W'(INIT2);
            st_q[2] <= W'(INIT3);
            for (int i = 0; i < NS; i++) d_q[i] <= '0;
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                st_q[0] <= ld_x1;
                st_q[1] <= ld_x2;
                st_q[2] <= ld_x3;
                phase   <= PH_IDLE;
            end else if (phase == PH_APPLY) begin
                for (int i = 0; i < NS; i++) st_q[i] <= st_nx[i];
                done  <= 1'b1;
                phase <= PH_IDLE;
            end else if (start) begin
                for (int i = 0; i < NS; i++) d_q[i] <= d_nx[i];
                phase <= PH_APPLY;
            end
        end
    end

    // R3: done never lasts more than one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3/R4: a pending step without load always completes at the next edge
    a_r4_pending_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_APPLY && !load) |=> done);
    // R5: no load and nothing pending keeps the state
    a_r5_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && phase == PH_IDLE) |=> ($stable(x1) && $stable(x2) && $stable(x3)));
    // R2: load writes the values and suppresses done
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (x1 == $past(ld_x1) && x2 == $past(ld_x2) && x3 == $past(ld_x3) && !done));
endmodule

// File: tb/test_pwl_euler_node.sv
// Scoreboard bench: driver tasks push expected states, a monitor pops on done.
module test_pwl_euler_node;
    localparam longint KA = 1022362, KBT = 1835008, KB = -46793, KH = -14057;
    localparam longint SMAX = 8388607, SMIN = -8388608;

    typedef struct {
        longint e1, e2, e3;
        string  tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, start = 1'b0;
    logic signed [23:0] ld_x1 = '0, ld_x2 = '0, ld_x3 = '0, coup_u = '0;
    logic signed [23:0] x1, x2, x3;
    logic done;

    int checks = 0, failures = 0;
    exp_t exp_q[$];
    longint m1, m2, m3;

    always #5 clk = ~clk;

    pwl_euler_node i_pwl_euler_node (.clk(clk), .rst_n(rst_n), .load(load),
        .ld_x1(ld_x1), .ld_x2(ld_x2), .ld_x3(ld_x3), .start(start),
        .coup_u(coup_u), .x1(x1), .x2(x2), .x3(x3), .done(done));

    function automatic longint rmul(longint a, longint k);
        return (a * k + 32768) >>> 16;
    endfunction

    function automatic longint sat24(longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic longint absl(longint v);
        return (v < 0) ? -v : v;
    endfunction

    // model of one step from the requirements R6..R10
    task automatic model_step(input longint u);
        longint f, d1, d2, d3;
        f  = rmul(m1, KB) + rmul(absl(m1 + 65536) - absl(m1 - 65536), KH);
        d1 = rmul(m2 - m1 - f, KA) + u;
        d2 = m1 - m2 + m3;
        d3 = -rmul(m2, KBT);
        m1 = sat24(m1 + (d1 >>> 7));
        m2 = sat24(m2 + (d2 >>> 7));
        m3 = sat24(m3 + (d3 >>> 7));
    endtask

    task automatic check3(string tag, longint e1, longint e2, longint e3);
        checks++;
        if (longint'(x1) != e1 || longint'(x2) != e2 || longint'(x3) != e3) begin
            failures++;
            $display("FAIL %s: got %0d %0d %0d expected %0d %0d %0d",
                     tag, x1, x2, x3, e1, e2, e3);
        end
    endtask

    task automatic check_bit(string tag, logic got, logic want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", tag, got, want);
        end
    endtask

    // monitor: compare each done against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R3/R4 unexpected done: got done=1 expected 0");
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                check3(it.tag, it.e1, it.e2, it.e3);
            end
        end
    end

    task automatic drain();
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3 missing done: got %0d pending expected 0", exp_q.size());
            exp_q.delete();
        end
    endtask

    // driver: n steps with start held 2n cycles (odd edges accept, even edges ignored)
    task automatic run_steps(int n, longint u, string tag);
        @(negedge clk);
        coup_u = 24'(u);
        for (int s = 0; s < n; s++) begin
            exp_t it;
            model_step(u);
            it.e1 = m1; it.e2 = m2; it.e3 = m3; it.tag = tag;
            exp_q.push_back(it);
        end
        start = 1'b1;
        repeat (2 * n) @(negedge clk);
        start = 1'b0;
        drain();
    endtask

    task automatic load_state(longint a, longint b, longint c, string tag);
        @(negedge clk);
        load = 1'b1; ld_x1 = 24'(a); ld_x2 = 24'(b); ld_x3 = 24'(c);
        @(negedge clk);
        load = 1'b0;
        m1 = a; m2 = b; m3 = c;
        check3(tag, a, b, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 reset state", 32768, 16384, 8192);
        check_bit("R1 done after reset", done, 1'b0);
        m1 = 32768; m2 = 16384; m3 = 8192;

        run_steps(40, 0, "R9 chained steps from reset");
        run_steps(1, 0, "R4 start held two cycles gives one step");

        load_state(131072, 0, 0, "R2 load outer");
        run_steps(1, 0, "R6 outer segment x1=2.0");
        load_state(-32768, 6554, -13107, "R2 load inner");
        run_steps(1, 0, "R6 inner segment x1=-0.5");
        load_state(-196608, 65536, 32768, "R2 load negative outer");
        run_steps(1, 0, "R6 outer segment x1=-3.0");

        load_state(19661, -9830, 45875, "R2 load for coupling");
        run_steps(5, 49152, "R7 coupling +0.75");
        run_steps(5, -81920, "R7 coupling -1.25");
        run_steps(6, 0, "R8 second and third derivatives");

        // R5: idle hold while coupling input moves
        begin
            longint h1, h2, h3;
            h1 = x1; h2 = x2; h3 = x3;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                coup_u = 24'(i * 70000 - 300000);
            end
            check3("R5 idle hold", h1, h2, h3);
        end

        // R2: load cancels an accepted step
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; load = 1'b1; ld_x1 = 24'sd1000; ld_x2 = 24'sd2000; ld_x3 = -24'sd3000;
        @(negedge clk);
        load = 1'b0;
        check3("R2 load cancels pending step", 1000, 2000, -3000);
        check_bit("R2 no done on cancel", done, 1'b0);
        m1 = 1000; m2 = 2000; m3 = -3000;
        drain();

        // R2: load and start in the same cycle
        @(negedge clk);
        start = 1'b1; load = 1'b1; ld_x1 = 24'sd5000; ld_x2 = -24'sd7000; ld_x3 = 24'sd9000;
        @(negedge clk);
        start = 1'b0; load = 1'b0;
        check3("R2 load beats start", 5000, -7000, 9000);
        m1 = 5000; m2 = -7000; m3 = 9000;
        drain();

        // R10: clipping in both directions
        load_state(SMAX, SMAX, 0, "R2 load max");
        run_steps(1, 0, "R10 positive clip");
        checks++;
        if (longint'(x1) != SMAX) begin
            failures++;
            $display("FAIL R10 positive clip: got %0d expected %0d", x1, SMAX);
        end
        load_state(SMIN, SMIN, 0, "R2 load min");
        run_steps(1, 0, "R10 negative clip");
        checks++;
        if (longint'(x1) != SMIN) begin
            failures++;
            $display("FAIL R10 negative clip: got %0d expected %0d", x1, SMIN);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule